// File: doc/BRIEF.md
# Offset-Derived Cycle Timer Register

This block provides a 64-bit timer value to software without keeping that value in a register. A 63-bit running counter advances on every cycle in which the count-enable input is high. A separate 63-bit offset, set by software writes, is added to the counter on each read. Bit 63 of the timer is not part of the count: it is a control flag, set at reset, that writes replace and reads return as it was last written.

Three access selects reach this one timer: the plain tick view, the system tick view and the privileged tick view. A write through any of them loads the offset. The offset is chosen so that, in the cycle after the write, counter plus offset equals the low 63 bits of the written data. From then on the value advances with the counter. Reads return the sum with its two lowest bits cleared. The read result is registered and stays on the output until the next mapped read.

Top module: `tick_timer_reg`

## Requirements
- R1: After reset the flag is 1, the offset and the running count are 0, and the read-data output is 0. A read right after reset, with counting held off, returns 64'h8000_0000_0000_0000.
- R2: The running count goes up by exactly one on each clock edge at which `cnt_en` is high. It holds when `cnt_en` is low.
- R3: A mapped read in cycle N puts {flag, (count + offset)[62:2], 2'b00} on `rd_data` from cycle N+1. The two lowest bits are always 0.
- R4: Select codes 0 (tick), 1 (system tick) and 2 (privileged tick) reach the same timer. A write through one of them is seen by reads through the others.
- R5: After a mapped write in cycle N, the visible value in cycle N+1 equals `wr_data[62:0]`, whatever `cnt_en` was in cycle N, and the flag equals `wr_data[63]`. A read in cycle N+1 therefore returns the written data with bits 1:0 cleared.
- R6: When a mapped read and a mapped write fall in the same cycle, the read returns the value from before the write. The new value is visible from the next cycle.
- R7: Counter-plus-offset arithmetic wraps modulo 2^63 and never carries into bit 63. Bit 63 always shows the flag.
- R8: Select code 3 is unmapped. A read with it leaves `rd_data` unchanged, and a write with it changes neither the offset nor the flag.
- R9: `rd_data` holds its value in every cycle without a mapped read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Advances the running count by one when high |
| rd_en | input | 1 | Read request for the selected view |
| wr_en | input | 1 | Write request for the selected view |
| sel | input | 2 | View select: 0 tick, 1 system tick, 2 privileged tick, 3 unmapped |
| wr_data | input | 64 | Write value: bit 63 is the flag, bits 62:0 the timer value |
| rd_data | output | 64 | Registered read result |

## Verification
A read and a write can arrive in the same cycle, and a write can coincide with a count step. The bench drives both overlaps directly with known values. It also drives them at random, with `cnt_en` toggling. A behavioural model keeps only the visible value and the flag. It serves each read before applying a write, and otherwise steps with the count. Its result is compared with `rd_data` on every clock. This shows whether the old value was returned and whether the written value appears exactly once, with no extra step from the count.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int TICK_W     = 64;
    localparam int VAL_W      = TICK_W - 1;
    localparam int LOW_CLR    = 2;
    localparam int SEL_W      = 2;
    localparam int NUM_VIEWS  = 3;

    typedef enum logic [SEL_W-1:0] {
        VIEW_TICK = 2'd0,
        VIEW_SYS  = 2'd1,
        VIEW_PRIV = 2'd2,
        VIEW_NONE = 2'd3
    } view_sel_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic             flag;
        logic [VAL_W-1:0] val;
    } tick_req_t;

    function automatic logic [TICK_W-1:0] pack_view(input logic flag,
                                                    input logic [VAL_W-1:0] sum);
        logic [TICK_W-1:0] r;
        r = {flag, sum};
        r[LOW_CLR-1:0] = '0;
        return r;
    endfunction

endpackage

// File: rtl/tick_view_decode.sv
module tick_view_decode
    import tick_pkg::*;
#(
    parameter int N_VIEWS = NUM_VIEWS
) (
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    output logic             rd_hit,
    output logic             wr_hit
);
    logic [N_VIEWS-1:0] match;

    for (genvar g = 0; g < N_VIEWS; g++) begin : g_view
        assign match[g] = (sel == SEL_W'(g));
    end

    assign rd_hit = rd_en && (|match);
    assign wr_hit = wr_en && (|match);
endmodule

// File: rtl/tick_run_counter.sv
module tick_run_counter
    import tick_pkg::*;
#(
    parameter int CW = VAL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_en,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_next
);
    assign cnt_next = cnt_q + CW'(cnt_en);

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_next;
    end
endmodule

// File: rtl/tick_offset_store.sv
module tick_offset_store
    import tick_pkg::*;
#(
    parameter int CW = VAL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_hit,
    input  logic          wr_flag,
    input  logic [CW-1:0] wr_val,
    input  logic [CW-1:0] cnt_next,
    output logic [CW-1:0] offset_q,
    output logic          flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            offset_q <= '0;
            flag_q   <= 1'b1;
        end else if (wr_hit) begin
            offset_q <= wr_val - cnt_next;
            flag_q   <= wr_flag;
        end
    end
endmodule

// File: rtl/tick_read_port.sv
module tick_read_port
    import tick_pkg::*;
#(
    parameter int CW = VAL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_hit,
    input  logic          flag_q,
    input  logic [CW-1:0] cnt_q,
    input  logic [CW-1:0] offset_q,
    output logic [CW:0]   rd_q
);
    logic [CW-1:0] sum;

    assign sum = cnt_q + offset_q;

    always_ff @(posedge clk) begin
        if (rst)         rd_q <= '0;
        else if (rd_hit) rd_q <= pack_view(flag_q, sum);
    end
endmodule

// File: rtl/tick_timer_reg.sv
module tick_timer_reg
    import tick_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [TICK_W-1:0] wr_data,
    output logic [TICK_W-1:0] rd_data
);
    tick_req_t        req;
    logic             rd_hit;
    logic             wr_hit;
    logic [VAL_W-1:0] run_cnt;
    logic [VAL_W-1:0] run_next;
    logic [VAL_W-1:0] offset_q;
    logic             flag_q;

    tick_view_decode #(.N_VIEWS(NUM_VIEWS)) u_dec (
        .rd_en (rd_en),
        .wr_en (wr_en),
        .sel   (sel),
        .rd_hit(rd_hit),
        .wr_hit(wr_hit)
    );

    always_comb begin
        req.rd   = rd_hit;
        req.wr   = wr_hit;
        req.flag = wr_data[TICK_W-1];
        req.val  = wr_data[VAL_W-1:0];
    end

    tick_run_counter #(.CW(VAL_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (cnt_en),
        .cnt_q   (run_cnt),
        .cnt_next(run_next)
    );

    tick_offset_store #(.CW(VAL_W)) u_off (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (req.wr),
        .wr_flag (req.flag),
        .wr_val  (req.val),
        .cnt_next(run_next),
        .offset_q(offset_q),
        .flag_q  (flag_q)
    );

    tick_read_port #(.CW(VAL_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_hit  (req.rd),
        .flag_q  (flag_q),
        .cnt_q   (run_cnt),
        .offset_q(offset_q),
        .rd_q    (rd_data)
    );
endmodule

// File: rtl/tick_timer_reg_chk.sv
module tick_timer_reg_chk
    import tick_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cnt_en,
    input logic              rd_en,
    input logic              wr_en,
    input logic [SEL_W-1:0]  sel,
    input logic [TICK_W-1:0] wr_data,
    input logic [TICK_W-1:0] rd_data,
    input logic [VAL_W-1:0]  run_cnt,
    input logic [VAL_W-1:0]  offset_q,
    input logic              flag_q
);
    logic              mapped;
    logic              wq_valid;
    logic [TICK_W-1:0] wq_mask;

    assign mapped = (sel != 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            wq_valid <= 1'b0;
            wq_mask  <= '0;
        end else begin
            wq_valid <= wr_en && mapped;
            wq_mask  <= {wr_data[TICK_W-1:LOW_CLR], {LOW_CLR{1'b0}}};
        end
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flag_q && offset_q == '0 && run_cnt == '0 && rd_data == '0));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(run_cnt));

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_en |=> (run_cnt == $past(run_cnt) + 1'b1));

    p_low_clear_r3: assert property (@(posedge clk) disable iff (rst)
        rd_data[LOW_CLR-1:0] == '0);

    p_write_visible_r5: assert property (@(posedge clk) disable iff (rst)
        (wq_valid && rd_en && mapped) |=> (rd_data == $past(wq_mask)));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && mapped) |=> $stable(rd_data));

    p_unmapped_write_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mapped) |=> ($stable(offset_q) && $stable(flag_q)));
endmodule

bind tick_timer_reg tick_timer_reg_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt_en  (cnt_en),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .sel     (sel),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .run_cnt (run_cnt),
    .offset_q(offset_q),
    .flag_q  (flag_q)
);

// File: tb/tick_timer_reg_test.sv
module tick_timer_reg_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur_req = "R1";

    logic [62:0] m_vis  = '0;
    logic        m_flag = 1'b1;
    logic [63:0] m_rd   = '0;

    tick_timer_reg uut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .rd_en(rd_en),
        .wr_en(wr_en), .sel(sel), .wr_data(wr_data), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    // Reference model: keeps the visible value itself, never an offset.
    always @(posedge clk) begin
        if (rst) begin
            m_vis = '0; m_flag = 1'b1; m_rd = '0;
        end else begin
            if (rd_en && sel != 2'd3) m_rd = {m_flag, m_vis[62:2], 2'b00};
            if (wr_en && sel != 2'd3) begin
                m_vis  = wr_data[62:0];
                m_flag = wr_data[63];
            end else if (cnt_en) begin
                m_vis = m_vis + 63'd1;
            end
        end
    end

    always @(negedge clk) begin
        checks++;
        if (rd_data !== m_rd) begin
            fails++;
            $display("FAIL %s model compare: actual %h expected %h", cur_req, rd_data, m_rd);
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            finish_run();
        end
    end

    task automatic cyc(input logic en, input logic rd, input logic wr,
                       input logic [1:0] s, input logic [63:0] d);
        cnt_en = en; rd_en = rd; wr_en = wr; sel = s; wr_data = d;
        @(negedge clk);
    endtask

    task automatic expect_rd(input string req, input logic [63:0] exp);
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, rd_data, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_rd("R1", 64'h0);
        rst = 1'b0;
        // R1: first read after reset
        cyc(0, 1, 0, 2'd0, 64'h0);
        expect_rd("R1", 64'h8000_0000_0000_0000);
        // R2: ten counted cycles, then read
        cur_req = "R2";
        for (int i = 0; i < 10; i++) cyc(1, 0, 0, 2'd0, 64'h0);
        cyc(0, 1, 0, 2'd0, 64'h0);
        expect_rd("R2 R3", 64'h8000_0000_0000_0008);
        // R5 R4: write via system view while counting, read via privileged view
        cur_req = "R5";
        cyc(1, 0, 1, 2'd1, 64'h0123_4567_89AB_CDEF);
        cyc(1, 1, 0, 2'd2, 64'h0);
        expect_rd("R5 R4", 64'h0123_4567_89AB_CDEC);
        cyc(1, 1, 0, 2'd0, 64'h0);
        expect_rd("R4 R2", 64'h0123_4567_89AB_CDF0);
        // R9: idle cycles hold output
        cur_req = "R9";
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 2'd0, 64'h0);
        expect_rd("R9", 64'h0123_4567_89AB_CDF0);
        // R6: read and write together
        cur_req = "R6";
        cyc(0, 1, 1, 2'd0, 64'hFFFF_FFFF_FFFF_FFF0);
        expect_rd("R6 old", 64'h0123_4567_89AB_CDF4);
        cyc(1, 1, 0, 2'd1, 64'h0);
        expect_rd("R6 new", 64'hFFFF_FFFF_FFFF_FFF0);
        // R7: wrap of the 63-bit value keeps the flag
        cur_req = "R7";
        for (int i = 0; i < 15; i++) cyc(1, 0, 0, 2'd0, 64'h0);
        cyc(0, 1, 0, 2'd2, 64'h0);
        expect_rd("R7", 64'h8000_0000_0000_0000);
        // R8: unmapped select
        cur_req = "R8";
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 2'd0, 64'h0);
        cyc(0, 1, 1, 2'd3, 64'h0000_0000_0000_1234);
        expect_rd("R8 read", 64'h8000_0000_0000_0000);
        cyc(0, 1, 0, 2'd0, 64'h0);
        expect_rd("R8 write", 64'h8000_0000_0000_0004);
        // Random overlap of reads, writes and count steps
        cur_req = "R4 R5 R6";
        for (int i = 0; i < 400; i++) begin
            logic [63:0] d;
            d = {$urandom(), $urandom()};
            cyc(1'($urandom() % 2), 1'($urandom() % 2),
                ($urandom() % 5) == 0, 2'($urandom() % 4), d);
        end
        cyc(0, 0, 0, 2'd0, 64'h0);
        finish_run();
    end
endmodule